// File: doc/BRIEF.md
# Frame Grab Control Sequencer

This block decides, one video unit at a time, whether the unit is written to memory. A unit is the interval from a start-of-unit pulse to an end-of-unit pulse from the sync logic: a field when the source is interlaced, a frame otherwise. The block produces a capture gate that the pixel path uses to enable writes. It also produces a buffer-select bit that the address generator uses to pick one of two target buffers, a busy level and a one-cycle completion pulse.

Software controls the block through a small set of levels. A run level enables grabbing. A mode bit selects one grab or repeated grabs. Another bit restricts capture to one field parity. An optional decimation keeps one unit out of every n. A ping-pong enable makes the target buffer alternate after each completed grab. The gate only opens at a unit boundary, so a unit is never captured in part.

Top module: `grab_seq`

## Requirements
- R1: After reset, `cap_active`, `buf_sel`, `busy` and `done` are all 0.
- R2: `cap_active` rises in the cycle after a clock edge where `sof` is 1 and `run` is 1. If `run` goes high partway through a unit, nothing is captured until the next `sof`.
- R3: `cap_active` falls in the cycle after an edge where `eof` is 1 during a capture. `done` is 1 for exactly that cycle. `eof` outside a capture has no effect.
- R4: With `single_mode`=0, every eligible unit is captured for as long as `run` stays 1.
- R5: With `single_mode`=1, one unit is captured. No further unit is captured, and `busy` stays 0, until `run` has been 0 for at least one cycle and is set to 1 again.
- R6: With `field_mode`=1, only units whose `field_id` (sampled with `sof`) equals `field_sel` are eligible. With `field_mode`=0, every unit is eligible.
- R7: With `skip_en`=1, the first eligible unit after start is captured and then `skip_n`-1 eligible units are skipped, repeating. A `skip_n` of 0 or 1 captures every eligible unit. Clearing `run` or `skip_en` restarts the pattern.
- R8: `buf_sel` inverts at the completion of each capture while `dbuf_en`=1. It never changes at a skipped or ineligible unit, and never changes while `dbuf_en`=0.
- R9: Clearing `run` during a capture lets the unit finish at its `eof`, after which the block is idle.
- R10: When `eof` and `sof` fall on the same edge during a capture, the completion is reported (`done`, buffer toggle) and the next unit may start in that same edge, so `cap_active` stays 1. In single mode it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Grab enable level |
| single_mode | input | 1 | 1: one grab, 0: repeated |
| field_mode | input | 1 | 1: capture only the selected field parity |
| field_sel | input | 1 | Field parity to capture in field mode |
| skip_en | input | 1 | Enable keep-one-in-n decimation |
| skip_n | input | CNT_W | Decimation factor n |
| dbuf_en | input | 1 | Enable buffer ping-pong |
| sof | input | 1 | Start-of-unit pulse |
| eof | input | 1 | End-of-unit pulse |
| field_id | input | 1 | Parity of the unit, valid with `sof` |
| cap_active | output | 1 | Capture gate |
| buf_sel | output | 1 | Target buffer (0 = first buffer) |
| busy | output | 1 | Capturing or armed for a capture |
| done | output | 1 | One-cycle pulse on capture completion |

## Verification
Completion of one capture and the start of the next can land on the same edge when the sync logic places the end of one unit directly against the start of the following one. The bench provokes this by driving `eof` and `sof` together during an active capture, in continuous mode and then in single mode. In continuous mode the gate must stay high while `done` pulses and `buf_sel` inverts. In single mode the gate must drop and stay low. Random runs then mix all modes and compare each unit's gate, pulse and buffer bit against a bench-side model.

// File: rtl/grab_seq.sv
module grab_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             single_mode,
  input  logic             field_mode,
  input  logic             field_sel,
  input  logic             skip_en,
  input  logic [CNT_W-1:0] skip_n,
  input  logic             dbuf_en,
  input  logic             sof,
  input  logic             eof,
  input  logic             field_id,
  output logic             cap_active,
  output logic             buf_sel,
  output logic             busy,
  output logic             done
);
  logic             cap_q, buf_q, done_q, sdone_q;
  logic [CNT_W-1:0] cnt_q;

  wire ending    = cap_q & eof;
  wire free      = ~cap_q | eof;
  wire eligible  = ~field_mode | (field_id == field_sel);
  wire allow     = run & ~sdone_q & ~(ending & single_mode);
  wire open_unit = sof & free & allow & eligible;
  wire take      = open_unit & (~skip_en | (cnt_q == '0));
  wire skip      = open_unit & ~take;
  wire [CNT_W-1:0] reload = (skip_n > CNT_W'(1)) ? skip_n - CNT_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q   <= 1'b0;
      buf_q   <= 1'b0;
      done_q  <= 1'b0;
      sdone_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (take)        cap_q <= 1'b1;
      else if (ending) cap_q <= 1'b0;
      done_q <= ending;
      buf_q  <= buf_q ^ (ending & dbuf_en);
      if (!run)                      sdone_q <= 1'b0;
      else if (ending & single_mode) sdone_q <= 1'b1;
      if (!skip_en)   cnt_q <= '0;
      else if (take)  cnt_q <= reload;
      else if (skip)  cnt_q <= cnt_q - CNT_W'(1);
      else if (!run)  cnt_q <= '0;
    end
  end

  assign cap_active = cap_q;
  assign buf_sel    = buf_q;
  assign done       = done_q;
  assign busy       = cap_q | (run & ~sdone_q);
endmodule

module grab_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic field_mode,
  input logic field_sel,
  input logic dbuf_en,
  input logic sof,
  input logic eof,
  input logic field_id,
  input logic cap_active,
  input logic buf_sel,
  input logic done
);
  AST_START_ON_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_active) |-> ($past(sof) && $past(run))); // R2
  AST_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_active) |-> done); // R3
  AST_DONE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(eof)); // R3
  AST_FIELD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cap_active) && $past(field_mode)) |-> ($past(field_id) == $past(field_sel))); // R6
  AST_BUF_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_sel != $past(buf_sel)) |-> (done && $past(dbuf_en))); // R8
endmodule

bind grab_seq grab_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .field_mode(field_mode),
  .field_sel(field_sel), .dbuf_en(dbuf_en), .sof(sof), .eof(eof),
  .field_id(field_id), .cap_active(cap_active), .buf_sel(buf_sel), .done(done)
);

// File: tb/grab_seq_bench.sv
module grab_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 0, single_mode = 0, field_mode = 0, field_sel = 0;
  logic skip_en = 0, dbuf_en = 0, sof = 0, eof = 0, field_id = 0;
  logic [7:0] skip_n = 8'd0;
  logic cap_active, buf_sel, busy, done;

  int checks = 0, errors = 0;
  bit m_buf = 0, m_sdone = 0;
  int m_cnt = 0;

  always #4 clk = ~clk;

  grab_seq #(.CNT_W(8)) u_grab_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .single_mode(single_mode),
    .field_mode(field_mode), .field_sel(field_sel), .skip_en(skip_en),
    .skip_n(skip_n), .dbuf_en(dbuf_en), .sof(sof), .eof(eof),
    .field_id(field_id), .cap_active(cap_active), .buf_sel(buf_sel),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int reload_of(input int n);
    return (n > 1) ? n - 1 : 0;
  endfunction

  task automatic do_reset();
    rst_n = 0; run = 0; sof = 0; eof = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_buf = 0; m_sdone = 0; m_cnt = 0;
    @(negedge clk);
  endtask

  task automatic set_run(input bit v);
    run = v;
    if (!v) begin m_sdone = 0; m_cnt = 0; end
    @(negedge clk);
  endtask

  task automatic unit(input bit fid, input int len);
    bit elig, allow, take;
    string tag;
    elig  = !field_mode || (fid == field_sel);
    allow = run && !m_sdone;
    take  = allow && elig && (!skip_en || m_cnt == 0);
    if (!skip_en) m_cnt = 0;
    else if (take) m_cnt = reload_of(int'(skip_n));
    else if (allow && elig) m_cnt = m_cnt - 1;
    tag = skip_en ? "R7" : (field_mode ? "R6" : "R4");
    sof = 1; field_id = fid;
    @(negedge clk);
    sof = 0;
    chk(tag, cap_active, take);
    repeat (len) @(negedge clk);
    eof = 1;
    @(negedge clk);
    eof = 0;
    if (take) m_buf = m_buf ^ dbuf_en;
    if (take && single_mode) m_sdone = 1;
    chk("R3", done, take);
    chk("R3", cap_active, 1'b0);
    chk("R8", buf_sel, m_buf);
    chk("R5", busy, run && !m_sdone);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1", cap_active, 0); chk("R1", buf_sel, 0);
    chk("R1", busy, 0);       chk("R1", done, 0);

    // R2: run rises mid-unit, no capture until next sof
    sof = 1; @(negedge clk); sof = 0;
    run = 1; @(negedge clk);
    chk("R2", cap_active, 0);
    eof = 1; @(negedge clk); eof = 0;
    chk("R3", done, 0);
    unit(0, 3);

    // R9: run cleared during capture
    sof = 1; @(negedge clk); sof = 0;
    chk("R9", cap_active, 1);
    run = 0; m_sdone = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    chk("R9", cap_active, 1);
    eof = 1; @(negedge clk); eof = 0;
    chk("R9", done, 1); chk("R9", cap_active, 0); chk("R9", busy, 0);
    sof = 1; @(negedge clk); sof = 0;
    chk("R9", cap_active, 0);
    @(negedge clk);

    // R10: back-to-back in continuous mode with ping-pong
    do_reset();
    dbuf_en = 1; set_run(1);
    sof = 1; @(negedge clk); sof = 0;
    repeat (2) @(negedge clk);
    sof = 1; eof = 1; @(negedge clk); sof = 0; eof = 0;
    chk("R10", cap_active, 1); chk("R10", done, 1); chk("R10", buf_sel, 1);
    repeat (2) @(negedge clk);
    eof = 1; @(negedge clk); eof = 0;
    chk("R10", buf_sel, 0); chk("R10", cap_active, 0);

    // R10 + R5: back-to-back in single mode stops
    single_mode = 1; set_run(0); set_run(1);
    sof = 1; @(negedge clk); sof = 0;
    repeat (2) @(negedge clk);
    sof = 1; eof = 1; @(negedge clk); sof = 0; eof = 0;
    chk("R10", cap_active, 0); chk("R10", done, 1); chk("R5", busy, 0);
    sof = 1; @(negedge clk); sof = 0;
    chk("R5", cap_active, 0);
    eof = 1; @(negedge clk); eof = 0;

    // R8: no toggle with ping-pong disabled
    do_reset();
    single_mode = 0; dbuf_en = 0; set_run(1);
    unit(1, 2);
    chk("R8", buf_sel, 0);

    // random mix
    do_reset();
    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 9) == 0) begin
        single_mode = $urandom_range(0, 1);
        field_mode  = $urandom_range(0, 1);
        field_sel   = $urandom_range(0, 1);
        skip_en     = $urandom_range(0, 1);
        skip_n      = 8'($urandom_range(0, 4));
        dbuf_en     = $urandom_range(0, 1);
        if (!skip_en) m_cnt = 0;
        set_run(0);
      end
      set_run($urandom_range(0, 7) != 0);
      unit(i[0], $urandom_range(1, 4));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule